// File: doc/BRIEF.md
# DMA Descriptor Fetch and Parameter Loader

This block loads the working parameters of one DMA channel. A one-cycle load request, raised when the channel is enabled or when a work unit ends in a flow mode that does not stop, captures the current parameter set. The parameter set is a next-descriptor pointer, a current-descriptor pointer, a start address, a configuration word, X and Y counts, and X and Y modifiers. The block decodes the flow mode and descriptor size from the configuration word. It then fetches the number of 16-bit descriptor halfwords that this mode requires, over a simple read port with a valid/ready handshake. Each halfword is written into its parameter register.

After the last halfword is stored, the block initialises the current address, the current descriptor pointer and the current X and Y counts. It decodes the element width from the final configuration word and flags a start address that is not aligned to that width. A request whose descriptor size does not suit its flow mode, or whose flow encoding is undefined, is rejected: the block reads nothing and raises the error flag. The block never moves data; a separate engine consumes the loaded parameters.

Top module: `dma_desc_loader`

## Requirements
- R1: After reset, busy, done, run, err and mem_rd_valid are 0, and every parameter output, current output and elem_bytes is 0.
- R2: Flow field in_cfg[14:12] values 0 (stop) and 1 (autobuffer) accept only a size field in_cfg[11:8] of 0. They issue no read, keep the captured inputs as parameters and pulse done.
- R3: Flow 4 (array) accepts a size of 1 to 7 halfwords. It reads them at in_desc_ptr + 2*i, and halfword i goes to parameter slot i.
- R4: Flow 6 (small list) accepts a size of 1 to 8 halfwords read at in_next_ptr + 2*i. The first halfword replaces only bits [15:0] of the next-descriptor pointer, and later halfwords shift down one slot.
- R5: Flow 7 (large list) accepts a size of 1 to 9 halfwords read at in_next_ptr + 2*i. Halfword 0 becomes bits [15:0] and halfword 1 becomes bits [31:16] of the next-descriptor pointer.
- R6: The halfwords that follow any pointer halfwords fill the slots in a fixed order: start [15:0], start [31:16], configuration, X count, X modify, Y count, Y modify.
- R7: A size outside the range of its flow mode, or flow value 2, 3 or 5, sets err, clears run, issues no read, leaves all parameter and current outputs unchanged, and pulses done on the next cycle.
- R8: Bits [3:2] of the final configuration word select the element width: 01 gives 2 bytes, 10 gives 4 bytes, 00 or 11 gives 1 byte. A final start address that is not a multiple of the width sets err while run stays 1.
- R9: On completion, cur_addr takes the final start address and cur_desc_ptr takes the final next-descriptor pointer. cur_xcnt and cur_ycnt take the final counts, with a count of zero becoming 16'hFFFF.
- R10: Reads go out one per accepted cycle at addresses rising by 2, and the address is held stable while mem_rd_ready is low. busy stays high from the accepted request until the loaded values appear, and done pulses for one cycle when they do.
- R11: A load request while busy is high is ignored; the load in progress completes with its own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_req | input | 1 | One-cycle request to load parameters |
| in_cfg | input | 16 | Configuration word in effect at the request |
| in_next_ptr | input | 32 | Next-descriptor pointer at the request |
| in_desc_ptr | input | 32 | Current-descriptor pointer at the request |
| in_start | input | 32 | Start address at the request |
| in_xcnt | input | 16 | X count at the request |
| in_xmod | input | 16 | X modify at the request |
| in_ycnt | input | 16 | Y count at the request |
| in_ymod | input | 16 | Y modify at the request |
| mem_rd_valid | output | 1 | Halfword read request |
| mem_rd_addr | output | 32 | Byte address of the halfword |
| mem_rd_ready | input | 1 | Read accepted; data valid in the same cycle |
| mem_rd_data | input | 16 | Read data |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle pulse when a load ends or is rejected |
| run | output | 1 | Channel running |
| err | output | 1 | Rejected request or misaligned start |
| elem_bytes | output | 3 | Decoded element width in bytes |
| out_next_ptr | output | 32 | Loaded next-descriptor pointer |
| out_start | output | 32 | Loaded start address |
| out_cfg | output | 16 | Loaded configuration word |
| out_xcnt | output | 16 | Loaded X count |
| out_xmod | output | 16 | Loaded X modify |
| out_ycnt | output | 16 | Loaded Y count |
| out_ymod | output | 16 | Loaded Y modify |
| cur_desc_ptr | output | 32 | Current descriptor pointer |
| cur_addr | output | 32 | Current address |
| cur_xcnt | output | 16 | Current X count |
| cur_ycnt | output | 16 | Current Y count |

## Verification
The hardest case to reach from the ports is a second load request that arrives in the middle of a fetch. The bench creates it by holding mem_rd_ready low, so the first fetch stalls with busy high, and then driving a request with a different configuration. It checks that the finished load reflects only the first request. A second hard case is a descriptor that rewrites the configuration word so that the loaded start address turns out misaligned. Random runs reach it through memory contents derived from the address, and a directed case forces it in stop mode.

// File: rtl/dma_ld_pkg.sv
package dma_ld_pkg;

  // flow mode encodings (in_cfg[14:12])
  localparam logic [2:0] FL_STOP  = 3'd0;
  localparam logic [2:0] FL_AUTO  = 3'd1;
  localparam logic [2:0] FL_ARRAY = 3'd4;
  localparam logic [2:0] FL_SMALL = 3'd6;
  localparam logic [2:0] FL_LARGE = 3'd7;

  // parameter slots; slots 0..6 are the fixed descriptor order
  localparam logic [3:0] SL_SLO = 4'd0;
  localparam logic [3:0] SL_SHI = 4'd1;
  localparam logic [3:0] SL_CFG = 4'd2;
  localparam logic [3:0] SL_XC  = 4'd3;
  localparam logic [3:0] SL_XM  = 4'd4;
  localparam logic [3:0] SL_YC  = 4'd5;
  localparam logic [3:0] SL_YM  = 4'd6;
  localparam logic [3:0] SL_PLO = 4'd7;
  localparam logic [3:0] SL_PHI = 4'd8;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_FINAL} ld_state_e;

  function automatic logic flow_known(input logic [2:0] flow);
    return (flow == FL_STOP) || (flow == FL_AUTO) || (flow == FL_ARRAY) ||
           (flow == FL_SMALL) || (flow == FL_LARGE);
  endfunction

  function automatic logic [3:0] size_limit(input logic [2:0] flow);
    case (flow)
      FL_ARRAY: return 4'd7;
      FL_SMALL: return 4'd8;
      FL_LARGE: return 4'd9;
      default:  return 4'd0;
    endcase
  endfunction

  function automatic logic size_fits(input logic [2:0] flow, input logic [3:0] nd);
    if (!flow_known(flow)) return 1'b0;
    if (size_limit(flow) == 4'd0) return nd == 4'd0;
    return (nd != 4'd0) && (nd <= size_limit(flow));
  endfunction

  function automatic logic [3:0] ptr_words(input logic [2:0] flow);
    case (flow)
      FL_LARGE: return 4'd2;
      FL_SMALL: return 4'd1;
      default:  return 4'd0;
    endcase
  endfunction

  function automatic logic [3:0] slot_of(input logic [2:0] flow, input logic [3:0] idx);
    logic [3:0] pw;
    pw = ptr_words(flow);
    if (idx < pw) return SL_PLO + idx;
    return idx - pw;
  endfunction

  function automatic logic [2:0] width_bytes(input logic [1:0] ws);
    case (ws)
      2'b01:   return 3'd2;
      2'b10:   return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic unaligned(input logic [1:0] lo, input logic [2:0] bytes);
    return |(lo & (bytes[1:0] - 2'd1));
  endfunction

endpackage

// File: rtl/dma_ld_decode.sv
module dma_ld_decode
  import dma_ld_pkg::*;
(
  input  logic [6:0] cfg_ctl,
  output logic [2:0] flow,
  output logic [3:0] nd,
  output logic       size_ok,
  output logic       from_desc
);
  assign flow      = cfg_ctl[6:4];
  assign nd        = cfg_ctl[3:0];
  assign size_ok   = size_fits(flow, nd);
  assign from_desc = (flow == FL_ARRAY);
endmodule

// File: rtl/dma_ld_seq.sv
module dma_ld_seq
  import dma_ld_pkg::*;
#(
  parameter int AW = 32
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_ok,
  input  logic          start_bad,
  input  logic [3:0]    nd,
  input  logic [AW-1:0] base_addr,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ready,
  output logic          hs,
  output logic [3:0]    hs_idx,
  output logic          finalize,
  output logic          busy,
  output logic          done
);
  localparam logic [AW-1:0] STEP = AW'(2);

  ld_state_e     state;
  logic [3:0]    idx;
  logic [3:0]    nd_q;
  logic [AW-1:0] addr;
  logic          hs_last;

  assign rd_valid = (state == ST_FETCH);
  assign rd_addr  = addr;
  assign hs       = rd_valid && rd_ready;
  assign hs_idx   = idx;
  assign hs_last  = hs && (idx == nd_q - 4'd1);
  assign finalize = (state == ST_FINAL);
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      nd_q  <= '0;
      addr  <= '0;
      done  <= 1'b0;
    end else begin
      done <= finalize || start_bad;
      case (state)
        ST_IDLE: begin
          if (start_ok) begin
            idx   <= '0;
            nd_q  <= nd;
            addr  <= base_addr;
            state <= (nd == 4'd0) ? ST_FINAL : ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (hs_last) begin
            state <= ST_FINAL;
          end else if (hs) begin
            idx  <= idx + 4'd1;
            addr <= addr + STEP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_no_read_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_valid);

  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  assert_addr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hs && !hs_last |=> rd_valid && (rd_addr == $past(rd_addr) + STEP));

  assert_idx_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hs |-> (hs_idx < nd_q) && (nd_q <= 4'd9));

endmodule

// File: rtl/dma_ld_regs.sv
module dma_ld_regs
  import dma_ld_pkg::*;
#(
  parameter int HWD = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             reject,
  input  logic [2:0]       flow,
  input  logic [HWD-1:0]   in_cfg,
  input  logic [2*HWD-1:0] in_next_ptr,
  input  logic [2*HWD-1:0] in_start,
  input  logic [HWD-1:0]   in_xcnt,
  input  logic [HWD-1:0]   in_xmod,
  input  logic [HWD-1:0]   in_ycnt,
  input  logic [HWD-1:0]   in_ymod,
  input  logic             wr_en,
  input  logic [3:0]       wr_idx,
  input  logic [HWD-1:0]   wr_data,
  input  logic             finalize,
  output logic [2*HWD-1:0] next_q,
  output logic [2*HWD-1:0] start_q,
  output logic [HWD-1:0]   cfg_q,
  output logic [HWD-1:0]   xcnt_q,
  output logic [HWD-1:0]   xmod_q,
  output logic [HWD-1:0]   ycnt_q,
  output logic [HWD-1:0]   ymod_q,
  output logic [2*HWD-1:0] cur_desc,
  output logic [2*HWD-1:0] cur_addr,
  output logic [HWD-1:0]   cur_x,
  output logic [HWD-1:0]   cur_y,
  output logic [2:0]       elem,
  output logic             run,
  output logic             err
);
  localparam logic [HWD-1:0] CNT_FULL = '1;

  logic [2:0] flow_q;
  logic [2:0] fin_bytes;

  function automatic logic [HWD-1:0] fill_count(input logic [HWD-1:0] c);
    return (c == '0) ? CNT_FULL : c;
  endfunction

  assign fin_bytes = width_bytes(cfg_q[3:2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flow_q   <= '0;
      next_q   <= '0;
      start_q  <= '0;
      cfg_q    <= '0;
      xcnt_q   <= '0;
      xmod_q   <= '0;
      ycnt_q   <= '0;
      ymod_q   <= '0;
      cur_desc <= '0;
      cur_addr <= '0;
      cur_x    <= '0;
      cur_y    <= '0;
      elem     <= '0;
      run      <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (capture) begin
        flow_q  <= flow;
        next_q  <= in_next_ptr;
        start_q <= in_start;
        cfg_q   <= in_cfg;
        xcnt_q  <= in_xcnt;
        xmod_q  <= in_xmod;
        ycnt_q  <= in_ycnt;
        ymod_q  <= in_ymod;
        run     <= 1'b1;
        err     <= 1'b0;
      end
      if (reject) begin
        run <= 1'b0;
        err <= 1'b1;
      end
      if (wr_en) begin
        case (slot_of(flow_q, wr_idx))
          SL_SLO:  start_q[HWD-1:0]     <= wr_data;
          SL_SHI:  start_q[2*HWD-1:HWD] <= wr_data;
          SL_CFG:  cfg_q                <= wr_data;
          SL_XC:   xcnt_q               <= wr_data;
          SL_XM:   xmod_q               <= wr_data;
          SL_YC:   ycnt_q               <= wr_data;
          SL_YM:   ymod_q               <= wr_data;
          SL_PLO:  next_q[HWD-1:0]      <= wr_data;
          SL_PHI:  next_q[2*HWD-1:HWD]  <= wr_data;
          default: ;
        endcase
      end
      if (finalize) begin
        cur_addr <= start_q;
        cur_desc <= next_q;
        cur_x    <= fill_count(xcnt_q);
        cur_y    <= fill_count(ycnt_q);
        elem     <= fin_bytes;
        if (unaligned(start_q[1:0], fin_bytes)) err <= 1'b1;
      end
    end
  end

  assert_count_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    finalize |=> (cur_x != '0) && (cur_y != '0));

  assert_width_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    finalize |=> $onehot0(elem) && (elem != 3'd0));

endmodule

// File: rtl/dma_desc_loader.sv
module dma_desc_loader
  import dma_ld_pkg::*;
#(
  parameter int HWD = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req,
  input  logic [HWD-1:0]    in_cfg,
  input  logic [2*HWD-1:0]  in_next_ptr,
  input  logic [2*HWD-1:0]  in_desc_ptr,
  input  logic [2*HWD-1:0]  in_start,
  input  logic [HWD-1:0]    in_xcnt,
  input  logic [HWD-1:0]    in_xmod,
  input  logic [HWD-1:0]    in_ycnt,
  input  logic [HWD-1:0]    in_ymod,
  output logic              mem_rd_valid,
  output logic [2*HWD-1:0]  mem_rd_addr,
  input  logic              mem_rd_ready,
  input  logic [HWD-1:0]    mem_rd_data,
  output logic              busy,
  output logic              done,
  output logic              run,
  output logic              err,
  output logic [2:0]        elem_bytes,
  output logic [2*HWD-1:0]  out_next_ptr,
  output logic [2*HWD-1:0]  out_start,
  output logic [HWD-1:0]    out_cfg,
  output logic [HWD-1:0]    out_xcnt,
  output logic [HWD-1:0]    out_xmod,
  output logic [HWD-1:0]    out_ycnt,
  output logic [HWD-1:0]    out_ymod,
  output logic [2*HWD-1:0]  cur_desc_ptr,
  output logic [2*HWD-1:0]  cur_addr,
  output logic [HWD-1:0]    cur_xcnt,
  output logic [HWD-1:0]    cur_ycnt
);
  localparam int AW = 2 * HWD;

  logic          accept;
  logic          start_ok;
  logic          start_bad;
  logic [2:0]    flow;
  logic [3:0]    nd;
  logic          size_ok;
  logic          from_desc;
  logic [AW-1:0] base_addr;
  logic          hs;
  logic [3:0]    hs_idx;
  logic          finalize;

  assign accept    = load_req && !busy;
  assign start_ok  = accept && size_ok;
  assign start_bad = accept && !size_ok;
  assign base_addr = from_desc ? in_desc_ptr : in_next_ptr;

  dma_ld_decode u_dec (
    .cfg_ctl   (in_cfg[14:8]),
    .flow      (flow),
    .nd        (nd),
    .size_ok   (size_ok),
    .from_desc (from_desc)
  );

  dma_ld_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ok  (start_ok),
    .start_bad (start_bad),
    .nd        (nd),
    .base_addr (base_addr),
    .rd_valid  (mem_rd_valid),
    .rd_addr   (mem_rd_addr),
    .rd_ready  (mem_rd_ready),
    .hs        (hs),
    .hs_idx    (hs_idx),
    .finalize  (finalize),
    .busy      (busy),
    .done      (done)
  );

  dma_ld_regs #(.HWD(HWD)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture     (start_ok),
    .reject      (start_bad),
    .flow        (flow),
    .in_cfg      (in_cfg),
    .in_next_ptr (in_next_ptr),
    .in_start    (in_start),
    .in_xcnt     (in_xcnt),
    .in_xmod     (in_xmod),
    .in_ycnt     (in_ycnt),
    .in_ymod     (in_ymod),
    .wr_en       (hs),
    .wr_idx      (hs_idx),
    .wr_data     (mem_rd_data),
    .finalize    (finalize),
    .next_q      (out_next_ptr),
    .start_q     (out_start),
    .cfg_q       (out_cfg),
    .xcnt_q      (out_xcnt),
    .xmod_q      (out_xmod),
    .ycnt_q      (out_ycnt),
    .ymod_q      (out_ymod),
    .cur_desc    (cur_desc_ptr),
    .cur_addr    (cur_addr),
    .cur_x       (cur_xcnt),
    .cur_y       (cur_ycnt),
    .elem        (elem_bytes),
    .run         (run),
    .err         (err)
  );

  assert_reject_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> err && !run && !busy && done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_rd_valid);

  assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> busy && run);

  assert_busy_ignores_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && load_req && !finalize |=> busy);

endmodule

// File: tb/dma_desc_loader_test.sv
`timescale 1ns/1ps
module dma_desc_loader_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_req = 1'b0;
  logic [15:0] in_cfg = '0;
  logic [31:0] in_next_ptr = '0, in_desc_ptr = '0, in_start = '0;
  logic [15:0] in_xcnt = '0, in_xmod = '0, in_ycnt = '0, in_ymod = '0;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_ready = 1'b0;
  logic [15:0] mem_rd_data;
  logic        busy, done, run, err;
  logic [2:0]  elem_bytes;
  logic [31:0] out_next_ptr, out_start, cur_desc_ptr, cur_addr;
  logic [15:0] out_cfg, out_xcnt, out_xmod, out_ycnt, out_ymod, cur_xcnt, cur_ycnt;

  always #4 clk = ~clk;

  dma_desc_loader uut (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .in_cfg(in_cfg),
    .in_next_ptr(in_next_ptr), .in_desc_ptr(in_desc_ptr), .in_start(in_start),
    .in_xcnt(in_xcnt), .in_xmod(in_xmod), .in_ycnt(in_ycnt), .in_ymod(in_ymod),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
    .busy(busy), .done(done), .run(run), .err(err), .elem_bytes(elem_bytes),
    .out_next_ptr(out_next_ptr), .out_start(out_start), .out_cfg(out_cfg),
    .out_xcnt(out_xcnt), .out_xmod(out_xmod), .out_ycnt(out_ycnt), .out_ymod(out_ymod),
    .cur_desc_ptr(cur_desc_ptr), .cur_addr(cur_addr),
    .cur_xcnt(cur_xcnt), .cur_ycnt(cur_ycnt)
  );

  int checks = 0;
  int errors = 0;

  function automatic logic [15:0] mem_fn(input logic [31:0] a);
    return {a[8:1], a[16:9]} ^ 16'h3C5A ^ a[31:16];
  endfunction

  assign mem_rd_data = mem_fn(mem_rd_addr);

  // memory ready: random unless held low
  bit hold_ready = 1'b0;
  always @(negedge clk) mem_rd_ready <= hold_ready ? 1'b0 : (($urandom % 4) != 0);

  // log of accepted read addresses
  logic [31:0] log_addr [0:15];
  int          nlog = 0;
  always @(posedge clk)
    if (mem_rd_valid && mem_rd_ready) begin
      if (nlog < 16) log_addr[nlog] <= mem_rd_addr;
      nlog <= nlog + 1;
    end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected model state
  logic [31:0] e_next = '0, e_start = '0, e_cdesc = '0, e_caddr = '0;
  logic [15:0] e_cfg = '0, e_xc = '0, e_xm = '0, e_yc = '0, e_ym = '0, e_cx = '0, e_cy = '0;
  logic [2:0]  e_elem = '0;
  bit          e_run = 0, e_err = 0, e_bad = 0;
  int          e_n = 0;
  logic [31:0] e_addr [0:15];

  function automatic int range_hi(input logic [2:0] f);
    case (f)
      3'd4: return 7;
      3'd6: return 8;
      3'd7: return 9;
      default: return 0;
    endcase
  endfunction

  task automatic model(input logic [15:0] cfg, input logic [31:0] np, input logic [31:0] dp,
                       input logic [31:0] st, input logic [15:0] xc, input logic [15:0] xm,
                       input logic [15:0] yc, input logic [15:0] ym);
    logic [2:0] f;
    int nd, lead, j;
    bit legal;
    logic [31:0] base;
    logic [15:0] d;
    f  = cfg[14:12];
    nd = int'(cfg[11:8]);
    if (f == 3'd0 || f == 3'd1) legal = (nd == 0);
    else if (f == 3'd4 || f == 3'd6 || f == 3'd7) legal = (nd >= 1) && (nd <= range_hi(f));
    else legal = 0;
    e_bad = !legal;
    if (!legal) begin
      e_err = 1; e_run = 0; e_n = 0;
      return;
    end
    e_next = np; e_start = st; e_cfg = cfg; e_xc = xc; e_xm = xm; e_yc = yc; e_ym = ym;
    base = (f == 3'd4) ? dp : np;
    lead = (f == 3'd7) ? 2 : ((f == 3'd6) ? 1 : 0);
    e_n  = nd;
    for (int i = 0; i < nd; i++) begin
      e_addr[i] = base + 32'(2 * i);
      d = mem_fn(e_addr[i]);
      if (i < lead) begin
        if (i == 0) e_next[15:0] = d; else e_next[31:16] = d;
      end else begin
        j = i - lead;
        case (j)
          0: e_start[15:0]  = d;
          1: e_start[31:16] = d;
          2: e_cfg = d;
          3: e_xc  = d;
          4: e_xm  = d;
          5: e_yc  = d;
          default: e_ym = d;
        endcase
      end
    end
    case (e_cfg[3:2])
      2'b01: e_elem = 3'd2;
      2'b10: e_elem = 3'd4;
      default: e_elem = 3'd1;
    endcase
    e_caddr = e_start;
    e_cdesc = e_next;
    e_cx = (e_xc == 16'd0) ? 16'hFFFF : e_xc;
    e_cy = (e_yc == 16'd0) ? 16'hFFFF : e_yc;
    e_run = 1;
    e_err = (e_start % 32'(e_elem)) != 0;
  endtask

  task automatic issue(input logic [15:0] cfg, input logic [31:0] np, input logic [31:0] dp,
                       input logic [31:0] st, input logic [15:0] xc, input logic [15:0] xm,
                       input logic [15:0] yc, input logic [15:0] ym);
    model(cfg, np, dp, st, xc, xm, yc, ym);
    @(negedge clk);
    nlog = 0;
    in_cfg = cfg; in_next_ptr = np; in_desc_ptr = dp; in_start = st;
    in_xcnt = xc; in_xmod = xm; in_ycnt = yc; in_ymod = ym;
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
  endtask

  task automatic await_check(input string tag);
    int t;
    t = 0;
    while (!done && t < 400) begin
      @(negedge clk);
      t++;
    end
    chk(done === 1'b1, {tag, " R10 done"}, 32'(done), 32'd1);
    chk(busy === 1'b0, {tag, " R10 busy low at done"}, 32'(busy), 32'd0);
    chk(nlog == e_n, {tag, " R10 read count"}, 32'(nlog), 32'(e_n));
    for (int i = 0; i < e_n && i < nlog; i++)
      chk(log_addr[i] === e_addr[i], {tag, " R3 R4 R5 read address"}, log_addr[i], e_addr[i]);
    chk(err === e_err, {tag, e_bad ? " R7 err" : " R8 err"}, 32'(err), 32'(e_err));
    chk(run === e_run, {tag, e_bad ? " R7 run" : " R2 run"}, 32'(run), 32'(e_run));
    chk(out_next_ptr === e_next, {tag, " R4 R5 next ptr"}, out_next_ptr, e_next);
    chk(out_start === e_start, {tag, " R6 start"}, out_start, e_start);
    chk(out_cfg === e_cfg, {tag, " R6 cfg"}, 32'(out_cfg), 32'(e_cfg));
    chk({out_xcnt, out_xmod} === {e_xc, e_xm}, {tag, " R6 x fields"}, {out_xcnt, out_xmod}, {e_xc, e_xm});
    chk({out_ycnt, out_ymod} === {e_yc, e_ym}, {tag, " R6 y fields"}, {out_ycnt, out_ymod}, {e_yc, e_ym});
    chk(cur_addr === e_caddr, {tag, " R9 cur addr"}, cur_addr, e_caddr);
    chk(cur_desc_ptr === e_cdesc, {tag, " R9 cur desc"}, cur_desc_ptr, e_cdesc);
    chk({cur_xcnt, cur_ycnt} === {e_cx, e_cy}, {tag, " R9 cur counts"}, {cur_xcnt, cur_ycnt}, {e_cx, e_cy});
    chk(elem_bytes === e_elem, {tag, " R8 elem bytes"}, 32'(elem_bytes), 32'(e_elem));
    @(negedge clk);
    chk(done === 1'b0, {tag, " R10 done one cycle"}, 32'(done), 32'd0);
  endtask

  task automatic load(input string tag, input logic [15:0] cfg, input logic [31:0] np,
                      input logic [31:0] dp, input logic [31:0] st, input logic [15:0] xc,
                      input logic [15:0] xm, input logic [15:0] yc, input logic [15:0] ym);
    issue(cfg, np, dp, st, xc, xm, yc, ym);
    await_check(tag);
  endtask

  function automatic logic [15:0] mkcfg(input logic [2:0] f, input logic [3:0] nd, input logic [1:0] ws);
    return {1'b0, f, nd, 4'h0, ws, 2'b01};
  endfunction

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed_sink;
    logic [2:0] flows [0:7];
    seed_sink = $urandom(32'h5EED1234);
    flows[0] = 3'd0; flows[1] = 3'd1; flows[2] = 3'd4; flows[3] = 3'd6;
    flows[4] = 3'd7; flows[5] = 3'd2; flows[6] = 3'd3; flows[7] = 3'd5;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, done, run, err, mem_rd_valid} === 5'b0, "R1 flags", 32'({busy, done, run, err, mem_rd_valid}), 32'd0);
    chk(cur_addr === 32'd0 && cur_desc_ptr === 32'd0, "R1 current pointers", cur_addr, 32'd0);
    chk(out_next_ptr === 32'd0 && out_start === 32'd0, "R1 params", out_start, 32'd0);
    chk(elem_bytes === 3'd0 && cur_xcnt === 16'd0, "R1 width", 32'(elem_bytes), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    load("stop R2", mkcfg(3'd0, 4'd0, 2'b10), 32'h0000_4000, 32'h0, 32'h0000_1000, 16'd5, 16'd4, 16'd0, 16'd0);
    load("auto R2 R9", mkcfg(3'd1, 4'd0, 2'b00), 32'h0000_5000, 32'h0, 32'h0000_1003, 16'd0, 16'd1, 16'd0, 16'd0);
    load("misaligned R8", mkcfg(3'd0, 4'd0, 2'b10), 32'h0000_6000, 32'h0, 32'h0000_0102, 16'd8, 16'd4, 16'd1, 16'd0);
    load("array7 R3", mkcfg(3'd4, 4'd7, 2'b01), 32'h0000_7000, 32'h0002_2000, 32'h0, 16'd1, 16'd2, 16'd3, 16'd4);
    load("small8 R4", mkcfg(3'd6, 4'd8, 2'b01), 32'h1234_8000, 32'h0, 32'h0, 16'd1, 16'd2, 16'd3, 16'd4);
    load("large9 R5", mkcfg(3'd7, 4'd9, 2'b00), 32'h0003_9000, 32'h0, 32'h0, 16'd1, 16'd2, 16'd3, 16'd4);
    load("large1 R5", mkcfg(3'd7, 4'd1, 2'b00), 32'hABCD_A000, 32'h0, 32'h10, 16'd7, 16'd2, 16'd3, 16'd4);
    load("stop size1 R7", mkcfg(3'd0, 4'd1, 2'b00), 32'h0000_B000, 32'h0, 32'h20, 16'd1, 16'd1, 16'd1, 16'd1);
    load("array0 R7", mkcfg(3'd4, 4'd0, 2'b00), 32'h0000_B000, 32'h0, 32'h20, 16'd1, 16'd1, 16'd1, 16'd1);
    load("array8 R7", mkcfg(3'd4, 4'd8, 2'b00), 32'h0000_B000, 32'h0, 32'h20, 16'd1, 16'd1, 16'd1, 16'd1);
    load("large10 R7", mkcfg(3'd7, 4'd10, 2'b00), 32'h0000_B000, 32'h0, 32'h20, 16'd1, 16'd1, 16'd1, 16'd1);
    load("flow5 R7", mkcfg(3'd5, 4'd2, 2'b00), 32'h0000_B000, 32'h0, 32'h20, 16'd1, 16'd1, 16'd1, 16'd1);

    // R11: second request during a stalled fetch
    hold_ready = 1'b1;
    issue(mkcfg(3'd4, 4'd3, 2'b01), 32'h0000_C000, 32'h0004_4000, 32'h0, 16'd9, 16'd2, 16'd9, 16'd2);
    @(negedge clk);
    chk(busy === 1'b1 && mem_rd_valid === 1'b1, "R10 R11 busy while stalled", 32'(busy), 32'd1);
    in_cfg = mkcfg(3'd7, 4'd9, 2'b00); in_next_ptr = 32'h0000_F000; in_desc_ptr = 32'h0;
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    in_cfg = mkcfg(3'd5, 4'd0, 2'b00);
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    chk(mem_rd_addr === 32'h0004_4000, "R10 R11 held address", mem_rd_addr, 32'h0004_4000);
    hold_ready = 1'b0;
    await_check("busy ignore R11");

    // constrained random loads
    for (int n = 0; n < 300; n++) begin
      logic [2:0] f;
      logic [3:0] nd;
      int hi;
      f = flows[$urandom % 8];
      hi = range_hi(f);
      if (($urandom % 4) == 0) nd = 4'($urandom % 16);
      else if (hi == 0) nd = 4'd0;
      else nd = 4'(1 + ($urandom % hi));
      load("random", {1'b0, f, nd, 8'($urandom)},
           $urandom, $urandom, $urandom,
           (($urandom % 5) == 0) ? 16'd0 : 16'($urandom), 16'($urandom),
           (($urandom % 5) == 0) ? 16'd0 : 16'($urandom), 16'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule